// File: doc/BRIEF.md
# Serial Mode-Control Register Bank

This block is the write-only control port of an audio converter core. An external controller sends 16-bit command frames over three wires: a serial clock, an active-low select and a data line. While select is low, one bit is captured on each rising serial clock edge, most significant bit first. A finished frame carries a 7-bit register index and an 8-bit payload. The frame's leading bit must be zero. Several frames may follow each other with no gap while select stays low. A frame that select cuts short is thrown away.

Each accepted frame is handed to the system clock domain through a toggle flag. The frame is decoded there into a write strobe for one of four mode registers. The fields of those registers drive the rest of the datapath: per-channel soft mute and attenuation, oversampling choice, right-channel polarity invert, analog mixing, de-emphasis, data format, zero-cross enable and power-down. The block also produces a reset for the datapath. This reset is held for a fixed number of system clocks after the hardware reset is released. It is also held for as long as the power-down bit is set. The power-down bit does not disturb the register contents; only the hardware reset does.

Top module: `ctlPortBank`

## Requirements
- R1: A frame is 16 bits sent most significant bit first. Bit 15 is a zero marker, bits 14..8 are the register index and bits 7..0 are the payload. A valid frame updates the addressed register a few system clocks after it completes, and no register changes without such a frame.
- R2: Index 1 holds the right mute in payload bit 7, the left mute in bit 6 and the 6-bit left attenuation in bits 5..0.
- R3: Index 2 holds the 6-bit right attenuation in payload bits 5..0. Payload bits 7..6 are not stored.
- R4: Index 3 holds the oversampling select in bit 7, the right polarity invert in bit 5, analog mixing in bit 4, de-emphasis in bit 3 and the 3-bit format code in bits 2..0. Bit 6 is not stored.
- R5: Index 4 holds zero-cross enable in bit 4 and power-down in bit 0. The other payload bits are not stored.
- R6: While the hardware reset is low, both attenuations are 63 and every other field is 0. A hardware reset after writes restores these values.
- R7: A frame whose bit 15 is 1 changes no register.
- R8: A frame whose index is 0 or 5..127 changes no register.
- R9: A frame with fewer than 16 bits before select rises is discarded, and the next frame starts again from bit 15.
- R10: Frames sent back to back while select stays low are each applied, in order.
- R11: After the hardware reset is released, the datapath reset output stays low for HOLD_CYCLES system clock edges and rises at the edge that ends them.
- R12: While the power-down field is 1, the datapath reset output is low. Setting and clearing power-down leaves every other register field unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Hardware reset, active low, asynchronous |
| serClk | input | 1 | Serial control clock; data sampled on rising edge |
| serSel | input | 1 | Serial select, active low |
| serData | input | 1 | Serial command data |
| muteL | output | 1 | Left soft mute |
| muteR | output | 1 | Right soft mute |
| attenL | output | 6 | Left attenuation step |
| attenR | output | 6 | Right attenuation step |
| overSel | output | 1 | Oversampling select |
| invertR | output | 1 | Right-channel polarity invert |
| mixEn | output | 1 | Analog mixing enable |
| deemphEn | output | 1 | De-emphasis enable |
| fmtSel | output | 3 | Audio data format code |
| zeroCrossEn | output | 1 | Zero-cross attenuation enable |
| powerDown | output | 1 | Software power-down |
| coreRstN | output | 1 | Datapath reset, active low |

## Verification
The bench sets HOLD_CYCLES to 16, so the reset hold window can be counted edge by edge in a short run. SYNC_STAGES stays at 2. With these values the bench can sweep every payload value into indices 1, 3 and 4, and every payload value into index 2. It also sends frames to every one of the 124 unused indices, so the full decode space is covered. Cut-short frames, back-to-back frames, a marker bit of 1, power-down toggling and a hardware reset in the middle of the run are each compared against a bench-side model of the register fields.

// File: rtl/ctl_port_pkg.sv
`timescale 1ns/1ps
package ctl_port_pkg;
  localparam int FRAME_BITS = 16;
  localparam int IDX_W      = 7;
  localparam int DATA_W     = 8;
  localparam int NUM_REGS   = 4;
  localparam int ATTEN_W    = 6;
  localparam int FMT_W      = 3;

  // payload bit positions decoded by the register file
  localparam int B_MUTE_R = 7;
  localparam int B_MUTE_L = 6;
  localparam int B_OVER   = 7;
  localparam int B_INV_R  = 5;
  localparam int B_MIX    = 4;
  localparam int B_DEEMPH = 3;
  localparam int B_ZCROSS = 4;
  localparam int B_PDOWN  = 0;

  localparam logic [ATTEN_W-1:0] ATTEN_DEFAULT = '1;

  typedef struct packed {
    logic [NUM_REGS-1:0] wrEn;
    logic [DATA_W-1:0]   wrData;
  } ctlStrobe_t;
endpackage

// File: rtl/ctlShifter.sv
`timescale 1ns/1ps
module ctlShifter #(
  parameter int FRAME_BITS = ctl_port_pkg::FRAME_BITS
) (
  input  logic                  rstN,
  input  logic                  serClk,
  input  logic                  serSel,
  input  logic                  serData,
  output logic [FRAME_BITS-1:0] frameWord,
  output logic                  frameTgl
);
  localparam int CNT_W = $clog2(FRAME_BITS);

  logic [CNT_W-1:0]      bitCnt;
  logic [FRAME_BITS-2:0] shiftReg;
  logic                  serClr;
  logic                  lastBit;

  // select high (or hardware reset) clears the bit position at once
  assign serClr  = ~rstN | serSel;
  assign lastBit = (bitCnt == CNT_W'(FRAME_BITS - 1));

  always_ff @(posedge serClk or posedge serClr) begin
    if (serClr)       bitCnt <= '0;
    else if (lastBit) bitCnt <= '0;
    else              bitCnt <= bitCnt + 1'b1;
  end

  always_ff @(posedge serClk) begin
    if (!serSel) shiftReg <= {shiftReg[FRAME_BITS-3:0], serData};
  end

  always_ff @(posedge serClk or negedge rstN) begin
    if (!rstN) begin
      frameWord <= '0;
      frameTgl  <= 1'b0;
    end else if (!serSel && lastBit) begin
      frameWord <= {shiftReg, serData};
      frameTgl  <= ~frameTgl;
    end
  end
endmodule

// File: rtl/ctlSyncDecode.sv
`timescale 1ns/1ps
module ctlSyncDecode
  import ctl_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 1024
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [FRAME_BITS-1:0] frameWord,
  input  logic                  frameTgl,
  input  logic                  powerDown,
  output ctlStrobe_t            stbQ,
  output logic                  coreRstN
);
  localparam int HC_W = $clog2(HOLD_CYCLES + 1);

  logic [SYNC_STAGES:0] tglPipe;
  logic                 newFrame;
  logic [IDX_W-1:0]     idx;
  logic                 leadBit;
  logic [NUM_REGS-1:0]  hit;
  ctlStrobe_t           stbComb;
  logic [HC_W-1:0]      holdCnt;
  logic                 holdDone;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) tglPipe <= '0;
    else       tglPipe <= {tglPipe[SYNC_STAGES-1:0], frameTgl};
  end

  assign newFrame = tglPipe[SYNC_STAGES] ^ tglPipe[SYNC_STAGES-1];
  assign leadBit  = frameWord[FRAME_BITS-1];
  assign idx      = frameWord[FRAME_BITS-2 -: IDX_W];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_hit
    assign hit[r] = newFrame && !leadBit && (idx == IDX_W'(r + 1));
  end

  assign stbComb.wrEn   = hit;
  assign stbComb.wrData = frameWord[DATA_W-1:0];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) stbQ <= '0;
    else       stbQ <= stbComb;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      holdCnt  <= '0;
      holdDone <= 1'b0;
    end else if (!holdDone) begin
      if (holdCnt == HC_W'(HOLD_CYCLES - 1)) holdDone <= 1'b1;
      else                                   holdCnt  <= holdCnt + 1'b1;
    end
  end

  assign coreRstN = holdDone & ~powerDown;
endmodule

// File: rtl/ctlRegFile.sv
`timescale 1ns/1ps
module ctlRegFile
  import ctl_port_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         stbQ,
  output logic               muteL,
  output logic               muteR,
  output logic [ATTEN_W-1:0] attenL,
  output logic [ATTEN_W-1:0] attenR,
  output logic               overSel,
  output logic               invertR,
  output logic               mixEn,
  output logic               deemphEn,
  output logic [FMT_W-1:0]   fmtSel,
  output logic               zeroCrossEn,
  output logic               powerDown
);
  logic [DATA_W-1:0] d;
  assign d = stbQ.wrData;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      muteR  <= 1'b0;
      muteL  <= 1'b0;
      attenL <= ATTEN_DEFAULT;
    end else if (stbQ.wrEn[0]) begin
      muteR  <= d[B_MUTE_R];
      muteL  <= d[B_MUTE_L];
      attenL <= d[ATTEN_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              attenR <= ATTEN_DEFAULT;
    else if (stbQ.wrEn[1])  attenR <= d[ATTEN_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      overSel  <= 1'b0;
      invertR  <= 1'b0;
      mixEn    <= 1'b0;
      deemphEn <= 1'b0;
      fmtSel   <= '0;
    end else if (stbQ.wrEn[2]) begin
      overSel  <= d[B_OVER];
      invertR  <= d[B_INV_R];
      mixEn    <= d[B_MIX];
      deemphEn <= d[B_DEEMPH];
      fmtSel   <= d[FMT_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      zeroCrossEn <= 1'b0;
      powerDown   <= 1'b0;
    end else if (stbQ.wrEn[3]) begin
      zeroCrossEn <= d[B_ZCROSS];
      powerDown   <= d[B_PDOWN];
    end
  end
endmodule

// File: rtl/ctlPortBank.sv
`timescale 1ns/1ps
module ctlPortBank
  import ctl_port_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int HOLD_CYCLES = 1024
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serSel,
  input  logic               serData,
  output logic               muteL,
  output logic               muteR,
  output logic [ATTEN_W-1:0] attenL,
  output logic [ATTEN_W-1:0] attenR,
  output logic               overSel,
  output logic               invertR,
  output logic               mixEn,
  output logic               deemphEn,
  output logic [FMT_W-1:0]   fmtSel,
  output logic               zeroCrossEn,
  output logic               powerDown,
  output logic               coreRstN
);
  logic [FRAME_BITS-1:0] frameWord;
  logic                  frameTgl;
  ctlStrobe_t            stbQ;

  ctlShifter #(.FRAME_BITS(FRAME_BITS)) u_shift (
    .rstN(rstN), .serClk(serClk), .serSel(serSel), .serData(serData),
    .frameWord(frameWord), .frameTgl(frameTgl)
  );

  ctlSyncDecode #(.SYNC_STAGES(SYNC_STAGES), .HOLD_CYCLES(HOLD_CYCLES)) u_ctl (
    .clk(clk), .rstN(rstN), .frameWord(frameWord), .frameTgl(frameTgl),
    .powerDown(powerDown), .stbQ(stbQ), .coreRstN(coreRstN)
  );

  ctlRegFile u_regs (
    .clk(clk), .rstN(rstN), .stbQ(stbQ),
    .muteL(muteL), .muteR(muteR), .attenL(attenL), .attenR(attenR),
    .overSel(overSel), .invertR(invertR), .mixEn(mixEn), .deemphEn(deemphEn),
    .fmtSel(fmtSel), .zeroCrossEn(zeroCrossEn), .powerDown(powerDown)
  );
endmodule

// File: rtl/ctlPortChecker.sv
`timescale 1ns/1ps
module ctlPortChecker #(
  parameter int HOLD_CYCLES = 1024,
  parameter int NUM_REGS    = 4,
  parameter int FIELD_W     = 23
) (
  input logic               clk,
  input logic               rstN,
  input logic               coreRstN,
  input logic               powerDown,
  input logic [NUM_REGS-1:0] wrEn,
  input logic [FIELD_W-1:0] fields
);
  localparam int HC_W = $clog2(HOLD_CYCLES + 1);

  logic [HC_W-1:0] ckCnt;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                                ckCnt <= '0;
    else if (ckCnt != HC_W'(HOLD_CYCLES))     ckCnt <= ckCnt + 1'b1;
  end

  // R1: register fields move only after a decoded write strobe
  p_no_stray_write_r1: assert property (@(posedge clk) disable iff (!rstN)
    !(|wrEn) |=> $stable(fields));

  // R8: at most one register addressed per frame
  p_single_target_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(wrEn));

  // R11: datapath held in reset during the hold window
  p_hold_window_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ckCnt < HC_W'(HOLD_CYCLES)) |-> !coreRstN);

  // R11: datapath released once the window ends and power-down is clear
  p_hold_release_r11: assert property (@(posedge clk) disable iff (!rstN)
    (ckCnt == HC_W'(HOLD_CYCLES) && !powerDown) |-> coreRstN);

  // R12: power-down keeps the datapath in reset
  p_pdown_holds_r12: assert property (@(posedge clk) disable iff (!rstN)
    powerDown |-> !coreRstN);
endmodule

bind ctlPortBank ctlPortChecker #(.HOLD_CYCLES(HOLD_CYCLES), .NUM_REGS(4), .FIELD_W(23)) u_chk (
  .clk(clk), .rstN(rstN), .coreRstN(coreRstN), .powerDown(powerDown),
  .wrEn(stbQ.wrEn),
  .fields({muteL, muteR, attenL, attenR, overSel, invertR, mixEn, deemphEn,
           fmtSel, zeroCrossEn, powerDown})
);

// File: tb/tb_ctlPortBank.sv
`timescale 1ns/1ps
module tb_ctlPortBank;
  localparam int HOLD = 16;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serSel = 1'b1, serData = 1'b0;
  logic muteL, muteR, overSel, invertR, mixEn, deemphEn, zeroCrossEn, powerDown, coreRstN;
  logic [5:0] attenL, attenR;
  logic [2:0] fmtSel;

  int tests = 0;
  int fails = 0;

  // bench model of the register fields
  logic       mR, mL, ov, inv, mix, dem, zc, pd;
  logic [5:0] aL, aR;
  logic [2:0] fmt;

  always #10 clk = ~clk;

  ctlPortBank #(.SYNC_STAGES(2), .HOLD_CYCLES(HOLD)) dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serSel(serSel), .serData(serData),
    .muteL(muteL), .muteR(muteR), .attenL(attenL), .attenR(attenR),
    .overSel(overSel), .invertR(invertR), .mixEn(mixEn), .deemphEn(deemphEn),
    .fmtSel(fmtSel), .zeroCrossEn(zeroCrossEn), .powerDown(powerDown),
    .coreRstN(coreRstN)
  );

  task automatic modelDefaults();
    mR = 0; mL = 0; aL = 6'd63; aR = 6'd63;
    ov = 0; inv = 0; mix = 0; dem = 0; fmt = 0; zc = 0; pd = 0;
  endtask

  task automatic applyModel(input logic [15:0] w);
    if (!w[15]) begin
      case (w[14:8])
        7'd1: begin mR = w[7]; mL = w[6]; aL = w[5:0]; end
        7'd2: aR = w[5:0];
        7'd3: begin ov = w[7]; inv = w[5]; mix = w[4]; dem = w[3]; fmt = w[2:0]; end
        7'd4: begin zc = w[4]; pd = w[0]; end
        default: ;
      endcase
    end
  endtask

  task automatic checkAll(input string req, input logic expCore);
    logic [23:0] got, exp;
    got = {muteL, muteR, attenL, attenR, overSel, invertR, mixEn, deemphEn,
           fmtSel, zeroCrossEn, powerDown, coreRstN};
    exp = {mL, mR, aL, aR, ov, inv, mix, dem, fmt, zc, pd, expCore};
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic checkBit(input string req, input logic act, input logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic shiftBits(input logic [15:0] w, input int n);
    for (int i = 15; i > 15 - n; i--) begin
      serData = w[i];
      #15 serClk = 1'b1;
      #30 serClk = 1'b0;
      #15;
    end
  endtask

  task automatic settle();
    repeat (8) @(negedge clk);
  endtask

  task automatic writeWord(input logic [15:0] w);
    serSel = 1'b0;
    #20;
    shiftBits(w, 16);
    serSel = 1'b1;
    #20;
    applyModel(w);
    settle();
  endtask

  task automatic doReset();
    rstN = 1'b0;
    modelDefaults();
    repeat (3) @(negedge clk);
    checkAll("R6 reset values", 1'b0);
    rstN = 1'b1;
    repeat (HOLD - 1) @(negedge clk);
    checkBit("R11 still held", coreRstN, 1'b0);
    @(negedge clk);
    checkBit("R11 released", coreRstN, 1'b1);
  endtask

  initial begin
    #3_000_000;
    fails++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    modelDefaults();
    @(negedge clk);
    doReset();

    // R2: every payload into index 1
    for (int v = 0; v < 256; v++) begin
      writeWord({1'b0, 7'd1, 8'(v)});
      checkAll("R2 reg1 sweep", 1'b1);
    end
    // R3: every payload into index 2, upper bits not stored
    for (int v = 0; v < 256; v++) begin
      writeWord({1'b0, 7'd2, 8'(v)});
      checkAll("R3 reg2 sweep", 1'b1);
    end
    // R4: every payload into index 3
    for (int v = 0; v < 256; v++) begin
      writeWord({1'b0, 7'd3, 8'(v)});
      checkAll("R4 reg3 sweep", 1'b1);
    end
    // R5 / R12: every payload into index 4
    for (int v = 0; v < 256; v++) begin
      writeWord({1'b0, 7'd4, 8'(v)});
      checkAll("R5 reg4 sweep", !pd);
    end
    writeWord({1'b0, 7'd4, 8'h00});

    // R8: unused indices change nothing
    for (int ix = 0; ix < 128; ix++) begin
      if (ix < 1 || ix > 4) begin
        writeWord({1'b0, 7'(ix), 8'(ix) ^ 8'h5A});
        checkAll("R8 unused index", 1'b1);
      end
    end

    // R7: marker bit set on every valid index
    writeWord({1'b0, 7'd1, 8'h15});
    writeWord({1'b0, 7'd3, 8'h00});
    for (int ix = 1; ix <= 4; ix++) begin
      writeWord({1'b1, 7'(ix), 8'hFF});
      checkAll("R7 marker one ignored", 1'b1);
    end

    // R9: short frame discarded, next frame realigned
    serSel = 1'b0; #20;
    shiftBits({1'b0, 7'd2, 8'h05}, 9);
    serSel = 1'b1; #20;
    settle();
    checkAll("R9 short frame dropped", 1'b1);
    writeWord({1'b0, 7'd1, 8'hC7});
    checkAll("R9 frame after short", 1'b1);

    // R10: back-to-back frames under one select
    serSel = 1'b0; #20;
    shiftBits({1'b0, 7'd2, 8'h2A}, 16);
    shiftBits({1'b0, 7'd3, 8'hBE}, 16);
    shiftBits({1'b0, 7'd1, 8'h40}, 16);
    serSel = 1'b1; #20;
    applyModel({1'b0, 7'd2, 8'h2A});
    applyModel({1'b0, 7'd3, 8'hBE});
    applyModel({1'b0, 7'd1, 8'h40});
    settle();
    checkAll("R10 burst applied", 1'b1);
    serSel = 1'b0; #20;
    shiftBits({1'b0, 7'd2, 8'h11}, 16);
    shiftBits({1'b0, 7'd2, 8'h22}, 16);
    serSel = 1'b1; #20;
    applyModel({1'b0, 7'd2, 8'h11});
    applyModel({1'b0, 7'd2, 8'h22});
    settle();
    checkAll("R10 burst order last wins", 1'b1);

    // R12: power-down keeps registers and accepts writes
    writeWord({1'b0, 7'd4, 8'h01});
    checkAll("R12 power-down set", 1'b0);
    writeWord({1'b0, 7'd2, 8'h07});
    checkAll("R12 write during power-down", 1'b0);
    writeWord({1'b0, 7'd4, 8'h10});
    checkAll("R12 power-down cleared, fields kept", 1'b1);

    // R1: nothing moves while idle
    repeat (40) @(negedge clk);
    checkAll("R1 idle stable", 1'b1);

    // R6 / R11: hardware reset after writes
    doReset();
    writeWord({1'b0, 7'd3, 8'h2D});
    checkAll("R1 write after reset", 1'b1);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule